// File: doc/BRIEF.md
# Multi-Bank MISR Signature Compressor

This block reduces the contents of an address window, read from up to four memory banks at once, to a single 16-bit signature. Each bank owns a 16-bit multiple-input signature register (MISR). A run is launched by a one-cycle start pulse that carries a bank mask and an inclusive word-address window. Every selected bank reads the window twice through its own synchronous read port: once with rising addresses and then once with falling addresses. Each word is folded into that bank's register as it returns.

When both sweeps are done, the per-bank registers are merged into the bank-0 register in a fixed order. That value is published as the signature, and a one-cycle done pulse marks it. A typical use is a built-in self check of memory contents: software or a test sequencer starts a run and compares the result with a known-good value.

Top module: `misr_sig_top`

## Requirements
- R1: Every compression cycle updates a register as next = {cur[14:0], cur[15]^cur[4]^cur[2]^cur[1]} ^ din, where din is the 16-bit word being compressed.
- R2: An accepted start sets all bank registers to 0xFFFF. In the next cycle, each selected bank compresses the word 0xFFFF, which leaves it at 0x0001. For example, with mask 4'b0001 and an empty window, the signature is 0x0003.
- R3: When first <= last, each selected bank b issues read enables (rd_en_o[b]) with addresses first, first+1, ..., last, and then last, last-1, ..., first, for 2*(last-first+1) enables in total. Unselected banks issue no enables. Bank b's address is rd_addr_o[b*AW +: AW].
- R4: Read data is returned one cycle after the address is issued. The word compressed is the memory word at the issued address, including when the window holds a single word.
- R5: After the sweeps, if bit 0 of the mask is set, the bank-0 register compresses its own value. Then, for banks 1, 2 and 3 in that order, each selected bank's register value is compressed into the bank-0 register.
- R6: An unselected bank's register stays at 0xFFFF. If bank 0 is unselected, the merge starts from 0xFFFF, so a mask of 0 gives the signature 0xFFFF.
- R7: When first > last, both sweeps are skipped, no read enables are issued, and the seed and merge steps still run.
- R8: A start pulse that arrives while busy_o is high is ignored, together with its mask and window.
- R9: done_o is high for exactly one cycle, with busy_o low, in the cycle in which sig_o first shows the new signature. sig_o then holds its value until the next run completes.
- R10: After reset, busy_o and done_o are 0, sig_o is 0, and rd_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle run request |
| bank_sel_i | input | NB | Bank mask, bit b selects bank b |
| first_addr_i | input | AW | Lowest word address of the window |
| last_addr_i | input | AW | Highest word address of the window |
| rd_en_o | output | NB | Per-bank read enable |
| rd_addr_o | output | NB*AW | Per-bank read address, bank b at bits b*AW +: AW |
| rd_data_i | input | NB*16 | Per-bank read data, one cycle after the address, bank b at bits b*16 +: 16 |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse, signature valid |
| sig_o | output | 16 | Final signature |

## Verification
The assertions watch on every cycle that:
- unselected bank registers never leave 0xFFFF;
- each selected register holds 0x0001 after the seed step;
- issued addresses stay inside the latched window;
- a run can only be entered from idle;
- the latched window does not move while busy;
- done is a lone pulse outside busy.

Only the bench's scenarios can show that the signature value is right. That covers the up-then-down order of the words, the one-cycle data alignment, the order of the merge, and the handling of empty, single-word and unselected cases. A model computes the expected signature from the requirement equations over random memory images.

// File: rtl/misr_pkg.sv
package misr_pkg;

    localparam int SIG_W = 16;
    localparam logic [SIG_W-1:0] SIG_ONES = 16'hFFFF;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEED,
        PH_UP,
        PH_DOWN,
        PH_DRAIN,
        PH_FOLD
    } phase_e;

    // One compression cycle: shift left, feedback from taps 15,4,2,1, then XOR data.
    function automatic logic [SIG_W-1:0] misr_step(input logic [SIG_W-1:0] cur,
                                                   input logic [SIG_W-1:0] din);
        logic fb;
        fb = cur[15] ^ cur[4] ^ cur[2] ^ cur[1];
        return {cur[14:0], fb} ^ din;
    endfunction

endpackage

// File: rtl/misr_lane.sv
module misr_lane
    import misr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             en_i,
    input  logic [SIG_W-1:0] din_i,
    output logic [SIG_W-1:0] q_o
);

    logic [SIG_W-1:0] reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (init_i)
            reg_d = SIG_ONES;
        else if (en_i)
            reg_d = misr_step(reg_q, din_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= SIG_ONES;
        else        reg_q <= reg_d;
    end

    assign q_o = reg_q;

endmodule

// File: rtl/misr_seq.sv
module misr_seq
    import misr_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 4,
    localparam int FW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] first_i,
    input  logic [AW-1:0] last_i,
    output phase_e        phase_o,
    output logic [AW-1:0] addr_o,
    output logic          issue_o,
    output logic          vld_o,
    output logic [FW-1:0] fold_o,
    output logic          done_o,
    output logic          busy_o
);

    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] addr;
        logic [AW-1:0] first;
        logic [AW-1:0] last;
        logic          vld;
        logic [FW-1:0] fold;
        logic          done;
    } seq_t;

    seq_t st_d, st_q;
    logic issue;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.vld  = 1'b0;
        issue     = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.first = first_i;
                    st_d.last  = last_i;
                    st_d.phase = PH_SEED;
                end
            end
            PH_SEED: begin
                st_d.fold = '0;
                if (st_q.first <= st_q.last) begin
                    st_d.phase = PH_UP;
                    st_d.addr  = st_q.first;
                end else begin
                    st_d.phase = PH_FOLD;
                end
            end
            PH_UP: begin
                issue    = 1'b1;
                st_d.vld = 1'b1;
                if (st_q.addr == st_q.last) st_d.phase = PH_DOWN;
                else                        st_d.addr  = st_q.addr + 1'b1;
            end
            PH_DOWN: begin
                issue    = 1'b1;
                st_d.vld = 1'b1;
                if (st_q.addr == st_q.first) st_d.phase = PH_DRAIN;
                else                         st_d.addr  = st_q.addr - 1'b1;
            end
            PH_DRAIN: begin
                st_d.phase = PH_FOLD;
                st_d.fold  = '0;
            end
            PH_FOLD: begin
                if (st_q.fold == FW'(NB - 1)) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.fold = st_q.fold + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign addr_o  = st_q.addr;
    assign issue_o = issue;
    assign vld_o   = st_q.vld;
    assign fold_o  = st_q.fold;
    assign done_o  = st_q.done;
    assign busy_o  = (st_q.phase != PH_IDLE);

    // R8
    seed_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SEED) |-> ($past(st_q.phase) == PH_IDLE));

    // R8
    window_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(st_q.first) && $stable(st_q.last)));

    // R3
    addr_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (st_q.addr >= st_q.first && st_q.addr <= st_q.last));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/misr_sig_top.sv
module misr_sig_top
    import misr_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 4,
    localparam int FW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [NB-1:0]      bank_sel_i,
    input  logic [AW-1:0]      first_addr_i,
    input  logic [AW-1:0]      last_addr_i,
    output logic [NB-1:0]      rd_en_o,
    output logic [NB*AW-1:0]   rd_addr_o,
    input  logic [NB*SIG_W-1:0] rd_data_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [SIG_W-1:0]   sig_o
);

    typedef struct packed {
        logic [NB-1:0]    sel;
        logic [SIG_W-1:0] sig;
    } top_t;

    top_t st_d, st_q;

    phase_e          phase;
    logic [AW-1:0]   addr;
    logic            issue, vld, busy, done;
    logic [FW-1:0]   fold_idx;
    logic            accept;
    logic [NB-1:0]   lane_en;
    logic [SIG_W-1:0] lane_din [NB];
    logic [SIG_W-1:0] misr     [NB];

    assign accept = start_i && !busy;

    misr_seq #(.AW(AW), .NB(NB)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .first_i (first_addr_i),
        .last_i  (last_addr_i),
        .phase_o (phase),
        .addr_o  (addr),
        .issue_o (issue),
        .vld_o   (vld),
        .fold_o  (fold_idx),
        .done_o  (done),
        .busy_o  (busy)
    );

    // Lane control: seed, sweep data, then merge into lane 0.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            lane_en[b]  = 1'b0;
            lane_din[b] = SIG_ONES;
            if (phase == PH_SEED) begin
                lane_en[b] = st_q.sel[b];
            end else if (vld) begin
                lane_en[b]  = st_q.sel[b];
                lane_din[b] = rd_data_i[b*SIG_W +: SIG_W];
            end
        end
        if (phase == PH_FOLD) begin
            lane_en[0]  = st_q.sel[fold_idx];
            lane_din[0] = misr[fold_idx];
        end
    end

    always_comb begin
        st_d = st_q;
        if (accept) st_d.sel = bank_sel_i;
        if (phase == PH_FOLD && fold_idx == FW'(NB - 1))
            st_d.sig = lane_en[0] ? misr_step(misr[0], lane_din[0]) : misr[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar gb = 0; gb < NB; gb++) begin : g_lane
            misr_lane u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .init_i (accept),
                .en_i   (lane_en[gb]),
                .din_i  (lane_din[gb]),
                .q_o    (misr[gb])
            );

            assign rd_en_o[gb]                = issue && st_q.sel[gb];
            assign rd_addr_o[gb*AW +: AW]     = addr;

            // R2
            seed_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (phase != PH_SEED && $past(phase) == PH_SEED && st_q.sel[gb])
                    |-> (misr[gb] == 16'h0001));

            if (gb == 0) begin : g_b0
                // R6
                idle_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (busy && !st_q.sel[0] && phase != PH_FOLD && phase != PH_SEED)
                        |-> (misr[0] == SIG_ONES));
            end else begin : g_bn
                // R6
                idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (busy && phase != PH_SEED && !st_q.sel[gb]) |-> (misr[gb] == SIG_ONES));
            end
        end
    endgenerate

    assign busy_o = busy;
    assign done_o = done;
    assign sig_o  = st_q.sig;

    // R9
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R9
    sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$past(done_o) && busy_o) |-> $stable(sig_o));

endmodule

// File: tb/misr_sig_top_tb.sv
module misr_sig_top_tb;

    localparam int AW = 8;
    localparam int NB = 4;
    localparam int DEPTH = 1 << AW;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [NB-1:0]      bank_sel_i = '0;
    logic [AW-1:0]      first_addr_i = '0;
    logic [AW-1:0]      last_addr_i = '0;
    logic [NB-1:0]      rd_en_o;
    logic [NB*AW-1:0]   rd_addr_o;
    logic [NB*16-1:0]   rd_data_i = '0;
    logic               busy_o, done_o;
    logic [15:0]        sig_o;

    logic [15:0] mem [NB][DEPTH];

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    bit mon_on = 1'b0;
    int mon_first, mon_n;
    int en_cnt [NB];
    int addr_err;

    always #2.5 clk = ~clk;

    misr_sig_top #(.AW(AW), .NB(NB)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .bank_sel_i   (bank_sel_i),
        .first_addr_i (first_addr_i),
        .last_addr_i  (last_addr_i),
        .rd_en_o      (rd_en_o),
        .rd_addr_o    (rd_addr_o),
        .rd_data_i    (rd_data_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .sig_o        (sig_o)
    );

    // Synchronous memories with one-cycle read latency.
    always @(posedge clk) begin
        for (int b = 0; b < NB; b++)
            if (rd_en_o[b])
                rd_data_i[b*16 +: 16] <= mem[b][rd_addr_o[b*AW +: AW]];
    end

    // Address sequence monitor.
    always @(posedge clk) begin
        if (mon_on) begin
            for (int b = 0; b < NB; b++) begin
                if (rd_en_o[b]) begin
                    int p, ea;
                    p  = en_cnt[b];
                    ea = (p < mon_n) ? mon_first + p : mon_first + mon_n - 1 - (p - mon_n);
                    if (int'(rd_addr_o[b*AW +: AW]) != ea) addr_err++;
                    en_cnt[b]++;
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected under 190000", cycles);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] c, input logic [15:0] d);
        return {c[14:0], c[15] ^ c[4] ^ c[2] ^ c[1]} ^ d;
    endfunction

    function automatic logic [15:0] model(input logic [NB-1:0] sel, input int first, input int last);
        logic [15:0] m [NB];
        for (int b = 0; b < NB; b++) begin
            m[b] = 16'hFFFF;
            if (sel[b]) begin
                m[b] = step(m[b], 16'hFFFF);
                for (int a = first; a <= last; a++) m[b] = step(m[b], mem[b][a]);
                for (int a = last; a >= first; a--) m[b] = step(m[b], mem[b][a]);
            end
        end
        if (sel[0]) m[0] = step(m[0], m[0]);
        for (int k = 1; k < NB; k++)
            if (sel[k]) m[0] = step(m[0], m[k]);
        return m[0];
    endfunction

    task automatic run(input logic [NB-1:0] sel, input int first, input int last,
                       input bit poke, input string tag);
        logic [15:0] exp;
        int n, cyc;
        exp = model(sel, first, last);
        n = (first <= last) ? last - first + 1 : 0;
        @(negedge clk);
        for (int b = 0; b < NB; b++) en_cnt[b] = 0;
        addr_err  = 0;
        mon_first = first;
        mon_n     = n;
        mon_on    = 1'b1;
        start_i      = 1'b1;
        bank_sel_i   = sel;
        first_addr_i = AW'(first);
        last_addr_i  = AW'(last);
        @(negedge clk);
        start_i      = 1'b0;
        bank_sel_i   = NB'($urandom);
        first_addr_i = AW'($urandom);
        last_addr_i  = AW'($urandom);
        check(busy_o == 1'b1, {tag, " R8 busy after start"}, busy_o, 1);
        cyc = 0;
        while (!done_o && cyc < 5000) begin
            start_i = (poke && (cyc == 2 || cyc == 5)) ? 1'b1 : 1'b0;
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        mon_on  = 1'b0;
        check(done_o == 1'b1, {tag, " R9 done seen"}, done_o, 1);
        check(sig_o == exp, {tag, " R1 R5 signature"}, sig_o, exp);
        check(busy_o == 1'b0, {tag, " R9 busy low at done"}, busy_o, 0);
        check(addr_err == 0, {tag, " R3 address order"}, addr_err, 0);
        for (int b = 0; b < NB; b++) begin
            int e;
            e = sel[b] ? 2 * n : 0;
            check(en_cnt[b] == e, {tag, " R3 R7 enable count"}, en_cnt[b], e);
        end
        @(negedge clk);
        check(done_o == 1'b0, {tag, " R9 done one cycle"}, done_o, 0);
        check(sig_o == exp, {tag, " R9 signature held"}, sig_o, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < NB; b++)
            for (int a = 0; a < DEPTH; a++)
                mem[b][a] = 16'($urandom);

        repeat (3) @(negedge clk);
        // R10
        check(busy_o == 1'b0, "R10 busy reset", busy_o, 0);
        check(done_o == 1'b0, "R10 done reset", done_o, 0);
        check(sig_o == 16'h0, "R10 sig reset", sig_o, 0);
        check(rd_en_o == '0, "R10 rd_en reset", rd_en_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(4'b1111, 0, DEPTH - 1, 1'b0, "full");        // R1 R3 R5
        run(4'b1111, 37, 37, 1'b0, "single");            // R4
        run(4'b1111, 90, 12, 1'b0, "empty");             // R7
        run(4'b1110, 3, 20, 1'b0, "no_bank0");           // R6
        run(4'b0000, 5, 9, 1'b0, "no_banks");            // R6
        check(sig_o == 16'hFFFF, "R6 empty mask gives FFFF", sig_o, 16'hFFFF);
        run(4'b0001, 200, 100, 1'b0, "seed");            // R2
        check(sig_o == 16'h0003, "R2 seed-only signature", sig_o, 16'h0003);
        run(4'b1010, 10, 40, 1'b1, "poke");              // R8
        run(4'b0100, 250, 255, 1'b0, "top_edge");        // R3

        // R9: output holds while idle with inputs changing
        begin
            logic [15:0] held;
            held = sig_o;
            repeat (6) begin
                bank_sel_i   = NB'($urandom);
                first_addr_i = AW'($urandom);
                @(negedge clk);
            end
            check(sig_o == held, "R9 idle hold", sig_o, held);
        end

        for (int i = 0; i < 20; i++) begin
            int f, l;
            f = $urandom_range(0, DEPTH - 1);
            l = $urandom_range(0, DEPTH - 1);
            if (i % 5 != 4 && f > l) begin
                int t;
                t = f; f = l; l = t;
            end
            run(NB'($urandom), f, l, (i % 3) == 0, "random");
        end

        summary();
        $finish;
    end

endmodule